// File: doc/BRIEF.md
# Operand Bypass Select Logic

This block picks where each of the two source operands of the instruction in the register-read stage of a four-stage pipeline (fetch, register read, execute, write-back) comes from. An operand can come from the register file, from the result being computed in the execute stage, or from the data being written back in the last stage. For each read port it decodes the opcode class of the register-read instruction to decide whether that port is used and which register field feeds it. It decodes the opcode class of the execute-stage instruction to decide whether that instruction will write its destination. It then compares register numbers and drives a two-bit select into a three-way operand multiplexer, which is also part of the block.

The write-back source is qualified by the register-file write enable and write address that the write-back stage actually presents. That address may be the instruction's destination field or the fixed exception-link register, so the block matches on the address itself. When both downstream stages hold the same destination, the newer execute-stage value is used. Register 31 reads as zero and is never forwarded. All paths are combinational.

Top module: `opfwd_top`

## Requirements
- R1: Opcode classes (6-bit opcode): top two bits 2'b10 is a register-register ALU op (reads ports A and B, writes); top two bits 2'b11 is an ALU op with literal (reads port A only, writes); 6'b011000 load (reads A, writes); 6'b011001 store (reads A and B, no write); 6'b011011 jump and 6'b011100/6'b011101 branches (read A, write the link); every other opcode reads and writes nothing.
- R2: Port A select is 2'b01 (execute stage) when the register-read instruction uses port A, the execute-stage instruction's class writes a register, and the ra field equals the execute-stage rc field.
- R3: A port's select is 2'b10 (write-back) when the port is used, no execute-stage hit exists, wb_we is 1, and the port's source field equals wb_waddr, including the exception-link register 30.
- R4: When the execute stage and write-back stage both match a port, that port's select is 2'b01.
- R5: Port B uses the same rules as port A with its own comparison; its source field, driven on rf_raddr_b, is rc for a store and rb otherwise.
- R6: A source field equal to 31 gives select 2'b00 and an operand of zero, whatever the stages hold.
- R7: A port that the register-read instruction's class does not read gives select 2'b00 and passes the register-file value.
- R8: An execute-stage instruction whose class does not write a register (store or unknown opcode) never produces select 2'b01.
- R9: With wb_we at 0, a matching wb_waddr never produces select 2'b10.
- R10: The operand equals rf data for select 2'b00, alu_result for 2'b01 and wb_wdata for 2'b10, in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_op | input | 6 | Opcode of the register-read stage instruction |
| rf_ra | input | 5 | ra field (bits 20:16) of the register-read instruction |
| rf_rb | input | 5 | rb field (bits 15:11) of the register-read instruction |
| rf_rc | input | 5 | rc field (bits 25:21) of the register-read instruction |
| alu_op | input | 6 | Opcode of the execute-stage instruction |
| alu_rc | input | 5 | Destination field of the execute-stage instruction |
| wb_we | input | 1 | Register-file write enable from write-back |
| wb_waddr | input | 5 | Register-file write address from write-back |
| rf_rd_a | input | 32 | Register-file read data, port A |
| rf_rd_b | input | 32 | Register-file read data, port B |
| alu_result | input | 32 | Execute-stage result |
| wb_wdata | input | 32 | Write-back data |
| rf_raddr_b | output | 5 | Register number selected for port B |
| sel_a | output | 2 | Port A source select |
| sel_b | output | 2 | Port B source select |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
Directed vectors isolate each hit: an execute-stage match alone, a write-back match alone, both together (showing priority), a store reading rc on port B, and a literal op whose rb field matches but must be ignored. Further vectors cover a non-writing execute-stage instruction, a matching address with the write enable low, a write to the link register 30, and register 31 in every stage, which tell qualification apart from plain address equality. Pseudo-random vectors draw register fields from a small set so that collisions across both ports and both stages are frequent. Every operand value is distinct, so a wrong select shows up in the data as well.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  localparam int OPW = 6;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_ALU = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic rd_a;     // port A is a source
    logic rd_b;     // port B is a source
    logic b_is_rc;  // port B field comes from rc
    logic wr;       // instruction writes its destination
  } op_use_t;

  localparam logic [1:0]     CLS_ALU_RR  = 2'b10;
  localparam logic [1:0]     CLS_ALU_LIT = 2'b11;
  localparam logic [OPW-1:0] OPC_LOAD    = 6'b011000;
  localparam logic [OPW-1:0] OPC_STORE   = 6'b011001;
  localparam logic [OPW-1:0] OPC_JUMP    = 6'b011011;
  localparam logic [OPW-1:0] OPC_BR_EQ   = 6'b011100;
  localparam logic [OPW-1:0] OPC_BR_NE   = 6'b011101;

endpackage

// File: rtl/opfwd_decode.sv
module opfwd_decode
  import opfwd_pkg::*;
(
  input  logic [OPW-1:0] op,
  output op_use_t        use_o
);

  always_comb begin
    use_o = '0;
    if (op[OPW-1 -: 2] == CLS_ALU_RR) begin
      use_o.rd_a = 1'b1;
      use_o.rd_b = 1'b1;
      use_o.wr   = 1'b1;
    end else if (op[OPW-1 -: 2] == CLS_ALU_LIT) begin
      use_o.rd_a = 1'b1;
      use_o.wr   = 1'b1;
    end else begin
      unique case (op)
        OPC_LOAD: begin
          use_o.rd_a = 1'b1;
          use_o.wr   = 1'b1;
        end
        OPC_STORE: begin
          use_o.rd_a    = 1'b1;
          use_o.rd_b    = 1'b1;
          use_o.b_is_rc = 1'b1;
        end
        OPC_JUMP, OPC_BR_EQ, OPC_BR_NE: begin
          use_o.rd_a = 1'b1;
          use_o.wr   = 1'b1;
        end
        default: use_o = '0;
      endcase
    end
  end

  // R1: a store never claims a register write, and only stores steer port B to rc
  always_comb begin
    if (use_o.b_is_rc) begin
      p_store_no_write_r1: assert (!use_o.wr && use_o.rd_b)
        else $error("store decode inconsistent");
    end
  end

endmodule

// File: rtl/opfwd_match.sv
module opfwd_match
  import opfwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter int ZERO_REG = 31
) (
  input  logic          src_used,
  input  logic [AW-1:0] src_addr,
  input  logic          alu_wr,
  input  logic [AW-1:0] alu_dst,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_dst,
  output src_sel_e      sel
);

  localparam logic [AW-1:0] ZERO_ADDR = AW'(ZERO_REG);

  logic live_src;
  logic alu_hit;
  logic wb_hit;

  assign live_src = src_used && (src_addr != ZERO_ADDR);
  assign alu_hit  = live_src && alu_wr && (src_addr == alu_dst);
  assign wb_hit   = live_src && wb_we  && (src_addr == wb_dst);

  always_comb begin
    if (alu_hit)     sel = SRC_ALU;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  // R9: write-back is only chosen with the write enable high
  always_comb begin
    if (sel == SRC_WB) begin
      p_wb_needs_we_r9: assert (wb_we && wb_dst == src_addr)
        else $error("write-back bypass without write");
    end
  end

  // R8: execute-stage bypass only from a writing instruction
  always_comb begin
    if (sel == SRC_ALU) begin
      p_alu_needs_wr_r8: assert (alu_wr && alu_dst == src_addr)
        else $error("execute bypass from non-writer");
    end
  end

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
  import opfwd_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int ZERO_REG = 31
) (
  input  src_sel_e      sel,
  input  logic [AW-1:0] src_addr,
  input  logic [DW-1:0] rf_data,
  input  logic [DW-1:0] alu_data,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] opnd
);

  localparam logic [AW-1:0] ZERO_ADDR = AW'(ZERO_REG);

  always_comb begin
    if (src_addr == ZERO_ADDR) begin
      opnd = '0;
    end else begin
      unique case (sel)
        SRC_ALU: opnd = alu_data;
        SRC_WB:  opnd = wb_data;
        default: opnd = rf_data;
      endcase
    end
  end

endmodule

// File: rtl/opfwd_top.sv
module opfwd_top
  import opfwd_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int ZERO_REG = 31
) (
  input  logic [OPW-1:0] rf_op,
  input  logic [AW-1:0]  rf_ra,
  input  logic [AW-1:0]  rf_rb,
  input  logic [AW-1:0]  rf_rc,
  input  logic [OPW-1:0] alu_op,
  input  logic [AW-1:0]  alu_rc,
  input  logic           wb_we,
  input  logic [AW-1:0]  wb_waddr,
  input  logic [DW-1:0]  rf_rd_a,
  input  logic [DW-1:0]  rf_rd_b,
  input  logic [DW-1:0]  alu_result,
  input  logic [DW-1:0]  wb_wdata,
  output logic [AW-1:0]  rf_raddr_b,
  output logic [1:0]     sel_a,
  output logic [1:0]     sel_b,
  output logic [DW-1:0]  opnd_a,
  output logic [DW-1:0]  opnd_b
);

  localparam int NPORT = 2;
  localparam logic [AW-1:0] ZERO_ADDR = AW'(ZERO_REG);

  op_use_t rf_use;
  op_use_t alu_use;

  logic              port_used [NPORT];
  logic [AW-1:0]     port_addr [NPORT];
  logic [DW-1:0]     port_rf   [NPORT];
  src_sel_e          port_sel  [NPORT];
  logic [DW-1:0]     port_opnd [NPORT];

  opfwd_decode u_dec_rf  (.op(rf_op),  .use_o(rf_use));
  opfwd_decode u_dec_alu (.op(alu_op), .use_o(alu_use));

  assign port_used[0] = rf_use.rd_a;
  assign port_used[1] = rf_use.rd_b;
  assign port_addr[0] = rf_ra;
  assign port_addr[1] = rf_use.b_is_rc ? rf_rc : rf_rb;
  assign port_rf[0]   = rf_rd_a;
  assign port_rf[1]   = rf_rd_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    opfwd_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_match (
      .src_used (port_used[p]),
      .src_addr (port_addr[p]),
      .alu_wr   (alu_use.wr),
      .alu_dst  (alu_rc),
      .wb_we    (wb_we),
      .wb_dst   (wb_waddr),
      .sel      (port_sel[p])
    );

    opfwd_mux #(.DW(DW), .AW(AW), .ZERO_REG(ZERO_REG)) u_mux (
      .sel      (port_sel[p]),
      .src_addr (port_addr[p]),
      .rf_data  (port_rf[p]),
      .alu_data (alu_result),
      .wb_data  (wb_wdata),
      .opnd     (port_opnd[p])
    );

    // R6: register 31 is never forwarded and reads zero
    always_comb begin
      if (port_addr[p] == ZERO_ADDR) begin
        p_zero_reg_r6: assert (port_sel[p] == SRC_RF && port_opnd[p] == '0)
          else $error("register 31 forwarded or nonzero");
      end
    end

    // R7: an unread port never selects a bypass
    always_comb begin
      if (!port_used[p]) begin
        p_unused_port_r7: assert (port_sel[p] == SRC_RF)
          else $error("bypass on unread port");
      end
    end

    // R10: operand follows the chosen source
    always_comb begin
      if (port_sel[p] == SRC_ALU) begin
        p_mux_alu_r10: assert (port_opnd[p] == alu_result)
          else $error("operand not execute result");
      end
      if (port_sel[p] == SRC_WB) begin
        p_mux_wb_r10: assert (port_opnd[p] == wb_wdata)
          else $error("operand not write-back data");
      end
    end

    // R4: with both stages matching, the execute stage wins
    always_comb begin
      if (port_used[p] && port_addr[p] != ZERO_ADDR && alu_use.wr &&
          alu_rc == port_addr[p] && wb_we && wb_waddr == port_addr[p]) begin
        p_alu_priority_r4: assert (port_sel[p] == SRC_ALU)
          else $error("write-back won over execute stage");
      end
    end
  end

  assign rf_raddr_b = port_addr[1];
  assign sel_a      = port_sel[0];
  assign sel_b      = port_sel[1];
  assign opnd_a     = port_opnd[0];
  assign opnd_b     = port_opnd[1];

endmodule

// File: tb/opfwd_top_test.sv
module opfwd_top_test;

  logic clk;
  logic [5:0]  rf_op, alu_op;
  logic [4:0]  rf_ra, rf_rb, rf_rc, alu_rc, wb_waddr;
  logic        wb_we;
  logic [31:0] rf_rd_a, rf_rd_b, alu_result, wb_wdata;
  logic [4:0]  rf_raddr_b;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  opfwd_top uut (
    .rf_op(rf_op), .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_rc(rf_rc),
    .alu_op(alu_op), .alu_rc(alu_rc), .wb_we(wb_we), .wb_waddr(wb_waddr),
    .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .alu_result(alu_result),
    .wb_wdata(wb_wdata), .rf_raddr_b(rf_raddr_b), .sel_a(sel_a),
    .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // behavioural reference: classify by opcode
  function automatic int reads_port(input logic [5:0] op, input int port);
    int r;
    r = 0;
    if (op[5:4] == 2'b10) r = 1;
    else if (op[5:4] == 2'b11) r = (port == 0);
    else if (op == 6'b011001) r = 1;
    else if (op == 6'b011000 || op == 6'b011011 ||
             op == 6'b011100 || op == 6'b011101) r = (port == 0);
    return r;
  endfunction

  function automatic int writes_reg(input logic [5:0] op);
    return (op[5:4] == 2'b10 || op[5:4] == 2'b11 || op == 6'b011000 ||
            op == 6'b011011 || op == 6'b011100 || op == 6'b011101) ? 1 : 0;
  endfunction

  function automatic int field_of(input int port);
    if (port == 0) return int'(rf_ra);
    if (rf_op == 6'b011001) return int'(rf_rc);
    return int'(rf_rb);
  endfunction

  function automatic int model_sel(input int port);
    int f;
    f = field_of(port);
    if (f == 31 || reads_port(rf_op, port) == 0) return 0;
    if (writes_reg(alu_op) == 1 && f == int'(alu_rc)) return 1;
    if (wb_we && f == int'(wb_waddr)) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model_opnd(input int port);
    int s;
    s = model_sel(port);
    if (field_of(port) == 31) return 32'h0;
    if (s == 1) return alu_result;
    if (s == 2) return wb_wdata;
    return (port == 0) ? rf_rd_a : rf_rd_b;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] rop, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [4:0] rc,
                       input logic [5:0] aop, input logic [4:0] arc,
                       input logic we, input logic [4:0] wa);
    @(negedge clk);
    rf_op = rop; rf_ra = ra; rf_rb = rb; rf_rc = rc;
    alu_op = aop; alu_rc = arc; wb_we = we; wb_waddr = wa;
    rf_rd_a = $urandom | 32'h1; rf_rd_b = $urandom | 32'h2;
    alu_result = $urandom | 32'h4; wb_wdata = $urandom | 32'h8;
  endtask

  task automatic compare(input string req);
    @(posedge clk); #2;
    check(req, "sel_a", {30'h0, sel_a}, 32'(model_sel(0)));
    check(req, "sel_b", {30'h0, sel_b}, 32'(model_sel(1)));
    check(req, "opnd_a", opnd_a, model_opnd(0));
    check(req, "opnd_b", opnd_b, model_opnd(1));
    check(req, "raddr_b", {27'h0, rf_raddr_b}, 32'(field_of(1)));
  endtask

  function automatic logic [4:0] pick_reg();
    case ($urandom % 6)
      0: return 5'd3;
      1: return 5'd4;
      2: return 5'd30;
      3: return 5'd31;
      default: return 5'($urandom);
    endcase
  endfunction

  function automatic logic [5:0] pick_op();
    case ($urandom % 8)
      0: return 6'b100000;
      1: return 6'b110001;
      2: return 6'b011000;
      3: return 6'b011001;
      4: return 6'b011011;
      5: return 6'b011100;
      6: return 6'b011101;
      default: return 6'b000111;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // idle: unknown opcodes everywhere (R1, R7)
    apply(6'b000000, 5'd0, 5'd0, 5'd0, 6'b000000, 5'd0, 1'b0, 5'd0);
    compare("R1");
    check("R7", "idle sel_a", {30'h0, sel_a}, 32'd0);
    // execute-stage hit on port A (R2)
    apply(6'b100000, 5'd3, 5'd9, 5'd1, 6'b100000, 5'd3, 1'b1, 5'd7);
    compare("R2");
    check("R2", "sel_a alu", {30'h0, sel_a}, 32'd1);
    // write-back hit only (R3)
    apply(6'b110000, 5'd3, 5'd9, 5'd1, 6'b100000, 5'd7, 1'b1, 5'd3);
    compare("R3");
    check("R3", "sel_a wb", {30'h0, sel_a}, 32'd2);
    // both stages hit (R4)
    apply(6'b100000, 5'd3, 5'd3, 5'd1, 6'b100000, 5'd3, 1'b1, 5'd3);
    compare("R4");
    check("R4", "sel_b alu wins", {30'h0, sel_b}, 32'd1);
    // port B rb hit (R5)
    apply(6'b100000, 5'd8, 5'd3, 5'd1, 6'b110000, 5'd3, 1'b0, 5'd0);
    compare("R5");
    check("R5", "sel_b rb", {30'h0, sel_b}, 32'd1);
    // store reads rc on port B (R5)
    apply(6'b011001, 5'd8, 5'd9, 5'd4, 6'b011000, 5'd4, 1'b0, 5'd0);
    compare("R5");
    check("R5", "raddr_b rc", {27'h0, rf_raddr_b}, 32'd4);
    // literal op: rb matches but is not read (R7)
    apply(6'b110000, 5'd8, 5'd3, 5'd1, 6'b100000, 5'd3, 1'b1, 5'd3);
    compare("R7");
    check("R7", "opnd_b rf", opnd_b, rf_rd_b);
    // register 31 in every stage (R6)
    apply(6'b100000, 5'd31, 5'd31, 5'd1, 6'b100000, 5'd31, 1'b1, 5'd31);
    compare("R6");
    check("R6", "opnd_a zero", opnd_a, 32'h0);
    // execute stage is a store (R8)
    apply(6'b100000, 5'd3, 5'd3, 5'd1, 6'b011001, 5'd3, 1'b0, 5'd0);
    compare("R8");
    check("R8", "sel_a none", {30'h0, sel_a}, 32'd0);
    // write enable low with matching address (R9)
    apply(6'b100000, 5'd3, 5'd3, 5'd1, 6'b000000, 5'd3, 1'b0, 5'd3);
    compare("R9");
    check("R9", "sel_b none", {30'h0, sel_b}, 32'd0);
    // exception-link write-back (R3) and data path (R10)
    apply(6'b011011, 5'd30, 5'd0, 5'd0, 6'b000001, 5'd30, 1'b1, 5'd30);
    compare("R3");
    check("R10", "opnd_a wb data", opnd_a, wb_wdata);
    // random collisions
    for (int i = 0; i < 400; i++) begin
      apply(pick_op(), pick_reg(), pick_reg(), pick_reg(),
            pick_op(), pick_reg(), 1'($urandom), pick_reg());
      compare("R5");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule